// File: doc/BRIEF.md
# Interrupt Source Controller with Edge and Level Sources

This block is the source side of a two-level interrupt system. It owns a parameterised set of interrupt sources (16 by default). Each source is fixed at build time as either edge-triggered (message style) or level-sensitive. Each source keeps a destination server, a priority, a saved priority and a small set of status flags. Sources are identified towards the rest of the system by a global number, which is the local index plus a configurable base.

Wanted deliveries go out one at a time over a valid/ready channel that carries server, global number and priority. The downstream presenter answers later through two notification inputs. A reject means it could not take the interrupt. An end-of-interrupt means the handler has finished. A resend pulse asks the block to scan every source for work that should be offered again. A priority of all ones masks a source.

Edge and level sources react differently to the same events. An edge source remembers that it fired while masked, and remembers that it was turned away. A level source mirrors its input line and remembers whether it has already been handed over. A single-port read path returns a source's configuration one cycle after the index is given.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset every source reads back with priority 0xFF, saved priority 0xFF and server 0, and no presentation is offered. Whether a source is edge or level is kept across reset.
- R2: A presented source carries global number = local index + BASE. Reject and end-of-interrupt numbers are converted by subtracting BASE. A number below BASE or at/after BASE + NUM_SRC is ignored.
- R3: An edge source whose line rises while its priority is 0xFF presents nothing and records a masked-pending flag. A later configuration write with a priority other than 0xFF clears the flag and presents the source with its new server and priority.
- R4: An edge source whose line rises while unmasked is presented once with its configured server and priority.
- R5: A level source is presented when it is unmasked, its line is high and it is not already sent, evaluated on a line change, a configuration write or a resend. Presenting sets its sent flag, so it is not offered again while the line merely stays high.
- R6: A reject marks an edge source as rejected and clears a level source's sent flag. Neither is re-offered until a resend.
- R7: A resend re-presents each rejected edge source that is unmasked, clearing its rejected flag (a second resend yields nothing). It also re-evaluates every level source by the R5 rule.
- R8: An end-of-interrupt clears a level source's sent flag without re-presenting it. For an edge source it leaves the rejected and masked-pending flags untouched and only ends the outstanding delivery.
- R9: pres_valid and the offered fields stay unchanged until pres_ready. When several sources wait, the lowest local index goes first, one per handshake.
- R10: An edge source that fires again while its previous delivery is still outstanding is held back until a reject or end-of-interrupt for it arrives.
- R11: A configuration write updates server, priority and saved priority of the indexed source. These are read back on rd_server, rd_prio and rd_saved one cycle after rd_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_line | input | NUM_SRC | Source input lines (rising edge for edge sources, level for level sources) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | Destination server to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks) |
| cfg_saved | input | PRIO_W | Saved priority to store |
| rd_idx | input | IDX_W | Local index read |
| rd_server | output | SRV_W | Registered server of rd_idx |
| rd_prio | output | PRIO_W | Registered priority of rd_idx |
| rd_saved | output | PRIO_W | Registered saved priority of rd_idx |
| rej_valid | input | 1 | Reject notification strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend scan request |
| pres_valid | output | 1 | Presentation offered |
| pres_ready | input | 1 | Presenter takes the offer |
| pres_server | output | SRV_W | Destination server of the offer |
| pres_num | output | NUM_W | Global number of the offer |
| pres_prio | output | PRIO_W | Priority of the offer |

## Verification
The hardest state to reach is an edge source that carries the rejected flag and is then given an end-of-interrupt, because a normal presenter never sends both for one delivery. The bench drives the notification inputs directly: it presents a source, rejects it, completes it, and only then issues a resend, so a re-offer shows the flag survived. Back-pressure is reached by dropping pres_ready before two edges fire in the same cycle, which makes the held offer and the ascending order visible at the ports.

// File: rtl/isc_pkg.sv
package isc_pkg;
  // Per-source status bits. busy means "sent" for a level source and
  // "delivery outstanding" for an edge source.
  typedef struct packed {
    logic req;
    logic mpend;
    logic rej;
    logic busy;
  } isc_flags_t;
endpackage

// File: rtl/isc_source.sv
module isc_source
  import isc_pkg::*;
#(
  parameter int SRV_W  = 8,
  parameter int PRIO_W = 8,
  parameter bit LEVEL  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  input  logic              cfg_we,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              take,
  input  logic              rej_hit,
  input  logic              eoi_hit,
  input  logic              resend,
  output logic              elig,
  output logic [SRV_W-1:0]  server,
  output logic [PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0] saved
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  isc_flags_t        f_q, f_d;
  logic              line_q;
  logic [SRV_W-1:0]  srv_q, srv_d;
  logic [PRIO_W-1:0] prio_q, prio_d, sav_q, sav_d;
  logic              open_d, evt, trig;

  always_comb begin
    f_d    = f_q;
    srv_d  = cfg_we ? cfg_server : srv_q;
    prio_d = cfg_we ? cfg_prio   : prio_q;
    sav_d  = cfg_we ? cfg_saved  : sav_q;
    open_d = (prio_d != MASKED);
    evt    = (line_in != line_q) | cfg_we | resend;
    trig   = line_in & ~line_q;

    if (take) begin
      f_d.req = 1'b0;
      if (!LEVEL) f_d.busy = 1'b1;
    end
    if (rej_hit) begin
      f_d.busy = 1'b0;
      if (!LEVEL) f_d.rej = 1'b1;
    end
    if (eoi_hit) f_d.busy = 1'b0;

    if (LEVEL) begin
      if (evt && open_d && line_in && !f_d.busy && !f_d.req) begin
        f_d.req  = 1'b1;
        f_d.busy = 1'b1;
      end
    end else begin
      if (trig) begin
        if (open_d) f_d.req = 1'b1;
        else        f_d.mpend = 1'b1;
      end
      if (cfg_we && f_d.mpend && open_d) begin
        f_d.mpend = 1'b0;
        f_d.req   = 1'b1;
      end
      if (resend && f_d.rej) begin
        f_d.rej = 1'b0;
        if (open_d) f_d.req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= '0;
      line_q <= 1'b0;
      srv_q  <= '0;
      prio_q <= MASKED;
      sav_q  <= MASKED;
    end else begin
      f_q    <= f_d;
      line_q <= line_in;
      srv_q  <= srv_d;
      prio_q <= prio_d;
      sav_q  <= sav_d;
    end
  end

  assign elig   = f_q.req & (LEVEL | ~f_q.busy);
  assign server = srv_q;
  assign prio   = prio_q;
  assign saved  = sav_q;

  generate
    if (!LEVEL) begin : g_edge_chk
      AST_MPEND_MASKED: assert property (@(posedge clk) disable iff (rst)
        f_q.mpend |-> (prio_q == MASKED)); // R3
    end
  endgenerate
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/isc_present.sv
module isc_present #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4,
  parameter int SRV_W   = 8,
  parameter int PRIO_W  = 8,
  parameter int NUM_W   = 24,
  parameter int BASE    = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               found,
  input  logic [IDX_W-1:0]   pick_idx,
  input  logic [SRV_W-1:0]   pick_srv,
  input  logic [PRIO_W-1:0]  pick_prio,
  input  logic               pres_ready,
  output logic               pres_valid,
  output logic [IDX_W-1:0]   held_idx,
  output logic [SRV_W-1:0]   pres_server,
  output logic [NUM_W-1:0]   pres_num,
  output logic [PRIO_W-1:0]  pres_prio,
  output logic [NUM_SRC-1:0] take_vec
);
  localparam logic [NUM_W-1:0] BASE_NUM = NUM_W'(BASE);
  logic load;

  assign load = ~pres_valid | pres_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_valid  <= 1'b0;
      held_idx    <= '0;
      pres_server <= '0;
      pres_num    <= '0;
      pres_prio   <= '0;
    end else if (load) begin
      pres_valid  <= found;
      held_idx    <= pick_idx;
      pres_server <= pick_srv;
      pres_num    <= BASE_NUM + NUM_W'(pick_idx);
      pres_prio   <= pick_prio;
    end
  end

  always_comb begin
    take_vec = '0;
    if (pres_valid && pres_ready) take_vec[held_idx] = 1'b1;
  end

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (rst)
    pres_valid && !pres_ready |=> pres_valid && $stable(pres_num) && $stable(pres_prio) && $stable(pres_server)); // R9
  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (rst)
    pres_valid |-> (pres_num >= BASE_NUM) && (pres_num - BASE_NUM < NUM_W'(NUM_SRC))); // R2
  AST_NO_DUP: assert property (@(posedge clk) disable iff (rst)
    pres_valid && pres_ready |=> !(pres_valid && pres_num == $past(pres_num))); // R10
endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl #(
  parameter int                 NUM_SRC   = 16,
  parameter int                 SRV_W     = 8,
  parameter int                 PRIO_W    = 8,
  parameter int                 NUM_W     = 24,
  parameter int                 BASE      = 4096,
  parameter logic [NUM_SRC-1:0] LEVEL_MAP = 16'hFF00,
  localparam int                IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [SRV_W-1:0]   cfg_server,
  input  logic [PRIO_W-1:0]  cfg_prio,
  input  logic [PRIO_W-1:0]  cfg_saved,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [SRV_W-1:0]   rd_server,
  output logic [PRIO_W-1:0]  rd_prio,
  output logic [PRIO_W-1:0]  rd_saved,
  input  logic               rej_valid,
  input  logic [NUM_W-1:0]   rej_num,
  input  logic               eoi_valid,
  input  logic [NUM_W-1:0]   eoi_num,
  input  logic               resend,
  output logic               pres_valid,
  input  logic               pres_ready,
  output logic [SRV_W-1:0]   pres_server,
  output logic [NUM_W-1:0]   pres_num,
  output logic [PRIO_W-1:0]  pres_prio
);
  localparam logic [NUM_W-1:0] BASE_NUM = NUM_W'(BASE);

  logic [NUM_W-1:0]   rej_off, eoi_off;
  logic               rej_in, eoi_in;
  logic [NUM_SRC-1:0] elig, cand, take_vec;
  logic [SRV_W-1:0]   srv_a  [NUM_SRC];
  logic [PRIO_W-1:0]  prio_a [NUM_SRC];
  logic [PRIO_W-1:0]  sav_a  [NUM_SRC];
  logic               found;
  logic [IDX_W-1:0]   pick_idx, held_idx;

  // Global-to-local conversion of notification numbers
  assign rej_off = rej_num - BASE_NUM;
  assign eoi_off = eoi_num - BASE_NUM;
  assign rej_in  = rej_valid && (rej_num >= BASE_NUM) && (rej_off < NUM_W'(NUM_SRC));
  assign eoi_in  = eoi_valid && (eoi_num >= BASE_NUM) && (eoi_off < NUM_W'(NUM_SRC));

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      isc_source #(
        .SRV_W (SRV_W),
        .PRIO_W(PRIO_W),
        .LEVEL (LEVEL_MAP[i])
      ) u_src (
        .clk       (clk),
        .rst       (rst),
        .line_in   (src_line[i]),
        .cfg_we    (cfg_we && (cfg_idx == IDX_W'(i))),
        .cfg_server(cfg_server),
        .cfg_prio  (cfg_prio),
        .cfg_saved (cfg_saved),
        .take      (take_vec[i]),
        .rej_hit   (rej_in && (rej_off == NUM_W'(i))),
        .eoi_hit   (eoi_in && (eoi_off == NUM_W'(i))),
        .resend    (resend),
        .elig      (elig[i]),
        .server    (srv_a[i]),
        .prio      (prio_a[i]),
        .saved     (sav_a[i])
      );
      // The offer currently held may not be chosen again while it leaves.
      assign cand[i] = elig[i] & ~(pres_valid && (held_idx == IDX_W'(i)));
    end
  endgenerate

  isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand (cand),
    .found(found),
    .idx  (pick_idx)
  );

  isc_present #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SRV_W(SRV_W),
    .PRIO_W (PRIO_W),  .NUM_W(NUM_W), .BASE (BASE)
  ) u_pres (
    .clk        (clk),
    .rst        (rst),
    .found      (found),
    .pick_idx   (pick_idx),
    .pick_srv   (srv_a[pick_idx]),
    .pick_prio  (prio_a[pick_idx]),
    .pres_ready (pres_ready),
    .pres_valid (pres_valid),
    .held_idx   (held_idx),
    .pres_server(pres_server),
    .pres_num   (pres_num),
    .pres_prio  (pres_prio),
    .take_vec   (take_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_server <= '0;
      rd_prio   <= '0;
      rd_saved  <= '0;
    end else begin
      rd_server <= srv_a[rd_idx];
      rd_prio   <= prio_a[rd_idx];
      rd_saved  <= sav_a[rd_idx];
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !pres_valid); // R1
endmodule

// File: tb/intsrc_ctrl_bench.sv
module intsrc_ctrl_bench;
  localparam int N = 16;
  localparam logic [23:0] B = 24'h001000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] line = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [7:0]  cfg_server = '0, cfg_prio = '0, cfg_saved = '0;
  logic [3:0]  rd_idx = '0;
  logic [7:0]  rd_server, rd_prio, rd_saved;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend = 1'b0;
  logic [23:0] rej_num = '0, eoi_num = '0;
  logic        pres_valid;
  logic        pres_ready = 1'b1;
  logic [7:0]  pres_server, pres_prio;
  logic [23:0] pres_num;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  intsrc_ctrl u_intsrc_ctrl (
    .clk(clk), .rst(rst), .src_line(line),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
    .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
    .rd_idx(rd_idx), .rd_server(rd_server), .rd_prio(rd_prio), .rd_saved(rd_saved),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
    .pres_valid(pres_valid), .pres_ready(pres_ready),
    .pres_server(pres_server), .pres_num(pres_num), .pres_prio(pres_prio)
  );

  // Monitor: every handshake is compared with the scoreboard head
  always @(negedge clk) begin
    if (!rst && pres_valid && pres_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected offer actual=%h/%h/%h expected none",
                 cur_tag, pres_server, pres_num, pres_prio);
      end else begin
        logic [39:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({pres_server, pres_num, pres_prio} !== e) begin
          failures++;
          $display("FAIL %s offer actual=%h expected=%h", t,
                   {pres_server, pres_num, pres_prio}, e);
        end
      end
    end
  end

  task automatic expect_offer(input logic [7:0] s, input logic [23:0] n,
                              input logic [7:0] p, input string t);
    exp_q.push_back({s, n, p});
    tag_q.push_back(t);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int i, input logic [7:0] s, input logic [7:0] p,
                     input logic [7:0] sv);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 4'(i); cfg_server = s; cfg_prio = p; cfg_saved = sv;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int i);
    @(posedge clk); #1; line[i] = 1'b1;
    @(posedge clk); #1; line[i] = 1'b0;
  endtask

  task automatic set_line(input int i, input logic v);
    @(posedge clk); #1; line[i] = v;
  endtask

  task automatic do_reject(input logic [23:0] n);
    @(posedge clk); #1; rej_valid = 1'b1; rej_num = n;
    @(posedge clk); #1; rej_valid = 1'b0;
  endtask

  task automatic do_eoi(input logic [23:0] n);
    @(posedge clk); #1; eoi_valid = 1'b1; eoi_num = n;
    @(posedge clk); #1; eoi_valid = 1'b0;
  endtask

  task automatic do_resend();
    @(posedge clk); #1; resend = 1'b1;
    @(posedge clk); #1; resend = 1'b0;
  endtask

  task automatic drain(input string t);
    for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(posedge clk);
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing offers actual_pending=%0d expected=0", t, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // Quiet window: the monitor reports any offer seen here as unexpected
  task automatic quiet(input string t, input int n);
    cur_tag = t;
    checks++;
    tick(n);
  endtask

  task automatic read_chk(input int i, input logic [7:0] s, input logic [7:0] p,
                          input logic [7:0] sv, input string t);
    @(posedge clk); #1; rd_idx = 4'(i);
    @(posedge clk); @(negedge clk);
    checks++;
    if (rd_server !== s || rd_prio !== p || rd_saved !== sv) begin
      failures++;
      $display("FAIL %s read idx %0d actual=%h/%h/%h expected=%h/%h/%h", t, i,
               rd_server, rd_prio, rd_saved, s, p, sv);
    end
  endtask

  initial begin
    tick(4);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pres_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 pres_valid actual=%b expected=0", pres_valid);
    end
    read_chk(5, 8'h00, 8'hFF, 8'hFF, "R1");
    read_chk(12, 8'h00, 8'hFF, 8'hFF, "R1");

    // R4: unmasked edge source
    cur_tag = "R4";
    cfg(0, 8'h03, 8'h05, 8'h11);
    expect_offer(8'h03, B + 0, 8'h05, "R4");
    pulse(0);
    drain("R4");
    do_eoi(B + 0);

    // R3: masked edge then unmask by configuration
    pulse(2);
    quiet("R3", 10);
    expect_offer(8'h07, B + 2, 8'h04, "R3");
    cfg(2, 8'h07, 8'h04, 8'h22);
    drain("R3");
    do_eoi(B + 2);
    read_chk(2, 8'h07, 8'h04, 8'h22, "R11");

    // R10: retrigger while outstanding waits for end-of-interrupt
    expect_offer(8'h03, B + 0, 8'h05, "R10");
    pulse(0);
    drain("R10");
    pulse(0);
    quiet("R10", 10);
    expect_offer(8'h03, B + 0, 8'h05, "R10");
    do_eoi(B + 0);
    drain("R10");
    do_eoi(B + 0);

    // R6/R7 edge: reject, resend, second resend silent
    expect_offer(8'h03, B + 0, 8'h05, "R6");
    pulse(0);
    drain("R6");
    do_reject(B + 0);
    quiet("R6", 10);
    expect_offer(8'h03, B + 0, 8'h05, "R7");
    do_resend();
    drain("R7");
    do_eoi(B + 0);
    do_resend();
    quiet("R7", 10);

    // R5 level source
    cfg(8, 8'h02, 8'h06, 8'h33);
    expect_offer(8'h02, B + 8, 8'h06, "R5");
    set_line(8, 1'b1);
    drain("R5");
    quiet("R5", 10);
    do_eoi(B + 8);
    quiet("R8", 10);
    expect_offer(8'h02, B + 8, 8'h06, "R7");
    do_resend();
    drain("R7");
    do_reject(B + 8);
    quiet("R6", 8);
    expect_offer(8'h02, B + 8, 8'h06, "R6");
    do_resend();
    drain("R6");
    do_eoi(B + 8);
    set_line(8, 1'b0);
    do_resend();
    quiet("R5", 10);

    // R8 edge: end-of-interrupt leaves the rejected flag in place
    expect_offer(8'h03, B + 0, 8'h05, "R8");
    pulse(0);
    drain("R8");
    do_reject(B + 0);
    do_eoi(B + 0);
    quiet("R8", 6);
    expect_offer(8'h03, B + 0, 8'h05, "R8");
    do_resend();
    drain("R8");
    do_eoi(B + 0);

    // R2: out-of-range notification numbers are ignored
    cfg(1, 8'h09, 8'h02, 8'h44);
    expect_offer(8'h09, B + 1, 8'h02, "R2");
    pulse(1);
    drain("R2");
    do_reject(B + 24'd16);
    do_resend();
    quiet("R2", 8);
    do_eoi(B - 24'd1);
    pulse(1);
    quiet("R2", 8);
    expect_offer(8'h09, B + 1, 8'h02, "R2");
    do_eoi(B + 1);
    drain("R2");
    do_eoi(B + 1);

    // R9: back-pressure and ascending order
    cfg(1, 8'h01, 8'h01, 8'h55);
    cfg(3, 8'h03, 8'h03, 8'h66);
    @(posedge clk); #1; pres_ready = 1'b0; line[1] = 1'b1; line[3] = 1'b1;
    @(posedge clk); #1; line[1] = 1'b0; line[3] = 1'b0;
    tick(3);
    @(negedge clk);
    checks++;
    if (pres_valid !== 1'b1 || pres_num !== B + 1 || pres_server !== 8'h01) begin
      failures++;
      $display("FAIL R9 held offer actual=%b/%h expected=1/%h", pres_valid, pres_num, B + 1);
    end
    tick(3);
    @(negedge clk);
    checks++;
    if (pres_valid !== 1'b1 || pres_num !== B + 1 || pres_prio !== 8'h01) begin
      failures++;
      $display("FAIL R9 stable offer actual=%b/%h expected=1/%h", pres_valid, pres_num, B + 1);
    end
    expect_offer(8'h01, B + 1, 8'h01, "R9");
    expect_offer(8'h03, B + 3, 8'h03, "R9");
    @(posedge clk); #1; pres_ready = 1'b1;
    drain("R9");
    do_eoi(B + 1);
    do_eoi(B + 3);

    // R5/R11: masked level source becomes visible on configuration
    set_line(9, 1'b1);
    quiet("R5", 8);
    expect_offer(8'h04, B + 9, 8'h07, "R11");
    cfg(9, 8'h04, 8'h07, 8'h77);
    drain("R11");
    read_chk(9, 8'h04, 8'h07, 8'h77, "R11");
    set_line(9, 1'b0);
    do_eoi(B + 9);
    quiet("R5", 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule